// File: doc/BRIEF.md
# Two's-Complement Adder/Subtractor with Condition Flags

This block is a purely combinational adder/subtractor for signed two's-complement operands. A single mode input selects between sum and difference. The difference is produced without a second adder: every bit of the second operand passes through an XOR gate driven by the mode input, and the mode input also enters the low end of the carry chain as the carry-in. This turns the operand into its two's complement, so one ripple chain of full-adder cells serves both operations.

Three condition flags leave the block along with the result. The zero flag marks an all-zero result. The negative flag copies the result's top bit. The overflow flag marks a signed result that does not fit in the data width. A following comparison stage can derive equal, less-than and less-or-equal from these flags after a subtraction.

Overflow is judged from the sign of the conditioned operand, which is the one actually added, rather than from the raw second input. The carry out of the top cell is formed inside the chain and is not brought out.

Top module: `addsub_flags`

## Requirements
- R1: With `sub_mode` = 0, `sum` equals `opa + opb` modulo 2^DATA_W (DATA_W defaults to 32).
- R2: With `sub_mode` = 1, `sum` equals `opa - opb` modulo 2^DATA_W. This is computed as `opa + ~opb + 1`.
- R3: `flag_zero` is 1 exactly when every bit of `sum` is 0.
- R4: `flag_neg` is 1 exactly when bit DATA_W-1 of `sum` is 1.
- R5: `flag_ovf` is 1 when the first operand and the conditioned operand (`opb` XOR `sub_mode`) share a sign bit and the sign bit of `sum` differs from it. Examples: 0x7FFFFFFF+1 gives 0x80000000 with `flag_ovf` = 1. 0x80000000-1 gives 0x7FFFFFFF with `flag_ovf` = 1. 0-0x80000000 gives 0x80000000 with `flag_ovf` = 1.
- R6: `flag_ovf` is 0 whenever the first operand and the conditioned operand differ in sign. A carry out of the top bit, as in 0xFFFFFFFF+1, leaves no trace on any output besides `sum` = 0 and `flag_zero` = 1.
- R7: All outputs follow the inputs combinationally. There is no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | DATA_W | First operand, signed |
| opb | input | DATA_W | Second operand, signed |
| sub_mode | input | 1 | 0 selects addition, 1 selects subtraction |
| sum | output | DATA_W | Result, truncated to DATA_W bits |
| flag_zero | output | 1 | Result is all zeros |
| flag_ovf | output | 1 | Signed overflow of the operation |
| flag_neg | output | 1 | Top bit of the result |

## Verification
The vectors cover several distinct cases.
- Small positive sums, which keep every flag low.
- Sums that cancel to zero in both modes.
- Mixed-sign operands that yield a negative result without overflow.
- Overflow in both directions and in both modes, including subtraction of the most negative value. This case shows whether overflow is judged from the conditioned operand or from the raw one.
- An all-ones plus one sum, which separates a genuine signed overflow from a plain carry out of the top bit.

A pseudo-random sweep then compares every output against arithmetic computed in the bench at one bit wider than the data.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
   localparam int unsigned DEFAULT_W = 32;
   typedef enum logic {MODE_ADD = 1'b0, MODE_SUB = 1'b1} addsub_mode_e;
endpackage

// File: rtl/addsub_fa_cell.sv
module addsub_fa_cell (
   input  logic x_in,
   input  logic y_in,
   input  logic c_in,
   output logic s_out,
   output logic c_out
);
   logic half_p;
   always_comb begin
      half_p = x_in ^ y_in;
      s_out  = half_p ^ c_in;
      c_out  = (x_in & y_in) | (c_in & half_p);
   end
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] x_vec,
   input  logic [W-1:0] y_vec,
   input  logic         c_first,
   output logic [W-1:0] s_vec,
   output logic         c_last
);
   localparam int unsigned NCARRY = W + 1;

   if (W < 1) begin : g_bad_width
      $error("addsub_ripple: W must be at least 1");
   end

   logic [NCARRY-1:0] carry;
   assign carry[0] = c_first;

   for (genvar k = 0; k < W; k++) begin : g_cell
      addsub_fa_cell u_fa (
         .x_in  (x_vec[k]),
         .y_in  (y_vec[k]),
         .c_in  (carry[k]),
         .s_out (s_vec[k]),
         .c_out (carry[k+1])
      );
   end

   assign c_last = carry[W];
endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] res,
   input  logic         sgn_x,
   input  logic         sgn_y,
   output logic         z_o,
   output logic         v_o,
   output logic         n_o
);
   localparam int unsigned MSB = W - 1;

   always_comb begin
      z_o = ~(|res);
      n_o = res[MSB];
      v_o = (sgn_x & sgn_y & ~res[MSB]) | (~sgn_x & ~sgn_y & res[MSB]);
   end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
   import addsub_pkg::*;
#(
   parameter int unsigned DATA_W = DEFAULT_W
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic              sub_mode,
   output logic [DATA_W-1:0] sum,
   output logic              flag_zero,
   output logic              flag_ovf,
   output logic              flag_neg
);
   localparam int unsigned MSB  = DATA_W - 1;
   localparam int unsigned WIDE = DATA_W + 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("addsub_flags: DATA_W must be at least 2");
   end

   addsub_mode_e mode;
   logic [DATA_W-1:0] opb_cond;
   logic              carry_top;

   assign mode = addsub_mode_e'(sub_mode);

   for (genvar k = 0; k < DATA_W; k++) begin : g_cond
      assign opb_cond[k] = opb[k] ^ sub_mode;
   end

   addsub_ripple #(.W(DATA_W)) u_chain (
      .x_vec   (opa),
      .y_vec   (opb_cond),
      .c_first (sub_mode),
      .s_vec   (sum),
      .c_last  (carry_top)
   );

   addsub_flag_unit #(.W(DATA_W)) u_flags (
      .res   (sum),
      .sgn_x (opa[MSB]),
      .sgn_y (opb_cond[MSB]),
      .z_o   (flag_zero),
      .v_o   (flag_ovf),
      .n_o   (flag_neg)
   );

   logic              unused_carry;
   logic [WIDE-1:0]   ext_res;
   assign unused_carry = carry_top;

   always_comb begin
      if (mode == MODE_SUB)
         ext_res = {opa[MSB], opa} - {opb[MSB], opb};
      else
         ext_res = {opa[MSB], opa} + {opb[MSB], opb};
   end

   always_comb begin
      if (mode == MODE_ADD) begin
         assert_add_result_R1: assert (sum == DATA_W'(opa + opb))
            else $error("R1 sum mismatch");
      end else begin
         assert_sub_result_R2: assert (sum == DATA_W'(opa - opb))
            else $error("R2 difference mismatch");
      end
      assert_zero_flag_R3: assert (flag_zero == (sum == '0))
         else $error("R3 zero flag mismatch");
      assert_neg_flag_R4: assert (flag_neg == ($signed(sum) < 0))
         else $error("R4 negative flag mismatch");
      assert_overflow_R5: assert (flag_ovf == (ext_res[DATA_W] != ext_res[MSB]))
         else $error("R5 overflow flag mismatch");
      if (opa[MSB] != (opb[MSB] ^ sub_mode)) begin
         assert_no_overflow_R6: assert (!flag_ovf)
            else $error("R6 overflow on mixed signs");
      end
   end
endmodule

// File: tb/test_addsub_flags.sv
module test_addsub_flags;
   localparam int unsigned W = 32;
   localparam time CLK_PERIOD = 10ns;
   localparam int NVEC = 12;
   localparam int WATCHDOG_CYCLES = 100000;

   // a[99:68] b[67:36] sub[35] s[34:3] z[2] v[1] n[0]
   localparam logic [99:0] VEC [NVEC] = '{
      {32'd10,        32'd3,         1'b0, 32'd13,        1'b0, 1'b0, 1'b0},
      {32'd5,         32'hFFFFFFFB,  1'b0, 32'd0,         1'b1, 1'b0, 1'b0},
      {32'd3,         32'hFFFFFFF6,  1'b0, 32'hFFFFFFF9,  1'b0, 1'b0, 1'b1},
      {32'h7FFFFFFF,  32'd1,         1'b0, 32'h80000000,  1'b0, 1'b1, 1'b1},
      {32'h80000000,  32'd1,         1'b1, 32'h7FFFFFFF,  1'b0, 1'b1, 1'b0},
      {32'd42,        32'd42,        1'b1, 32'd0,         1'b1, 1'b0, 1'b0},
      {32'd5,         32'd8,         1'b1, 32'hFFFFFFFD,  1'b0, 1'b0, 1'b1},
      {32'h80000000,  32'h80000000,  1'b0, 32'd0,         1'b1, 1'b1, 1'b0},
      {32'd0,         32'h80000000,  1'b1, 32'h80000000,  1'b0, 1'b1, 1'b1},
      {32'hFFFFFFFF,  32'd1,         1'b0, 32'd0,         1'b1, 1'b0, 1'b0},
      {32'h7FFFFFFF,  32'hFFFFFFFF,  1'b1, 32'h80000000,  1'b0, 1'b1, 1'b1},
      {32'h80000000,  32'h7FFFFFFF,  1'b1, 32'd1,         1'b0, 1'b1, 1'b0}
   };

   logic clk = 1'b0;
   logic [W-1:0] opa = '0, opb = '0;
   logic sub_mode = 1'b0;
   logic [W-1:0] sum;
   logic flag_zero, flag_ovf, flag_neg;
   int n_checks = 0, n_fail = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   addsub_flags #(.DATA_W(W)) i_addsub_flags (
      .opa(opa), .opb(opb), .sub_mode(sub_mode), .sum(sum),
      .flag_zero(flag_zero), .flag_ovf(flag_ovf), .flag_neg(flag_neg)
   );

   task automatic chk(input string req, input string what,
                      input logic [W-1:0] got, input logic [W-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic m);
      @(negedge clk);
      opa = a; opb = b; sub_mode = m;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_all(input logic [W-1:0] es, input logic ez,
                            input logic ev, input logic en);
      chk(sub_mode ? "R2" : "R1", "sum", sum, es);
      chk("R3", "zero", W'(flag_zero), W'(ez));
      chk("R4", "neg", W'(flag_neg), W'(en));
      chk(ev ? "R5" : "R6", "ovf", W'(flag_ovf), W'(ev));
   endtask

   initial begin
      logic [W:0] wide;
      logic [W-1:0] lf;
      // R7: outputs follow inputs with no stored state
      apply('0, '0, 1'b0);
      check_all('0, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < NVEC; i++) begin
         apply(VEC[i][99:68], VEC[i][67:36], VEC[i][35]);
         check_all(VEC[i][34:3], VEC[i][2], VEC[i][1], VEC[i][0]);
      end
      // R7: return to an earlier input and see the earlier answer
      apply(32'd10, 32'd3, 1'b0);
      chk("R7", "sum after revisit", sum, 32'd13);
      // pseudo-random sweep, expected from wide signed arithmetic
      lf = 32'hACE1_2468;
      for (int i = 0; i < 40; i++) begin
         logic [W-1:0] a, b;
         logic m, ev;
         lf = {lf[W-2:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         a = lf;
         lf = {lf[W-2:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         b = (i % 5 == 0) ? a : lf;
         m = lf[3];
         if (m) wide = {a[W-1], a} - {b[W-1], b};
         else   wide = {a[W-1], a} + {b[W-1], b};
         ev = wide[W] ^ wide[W-1];
         apply(a, b, m);
         check_all(wide[W-1:0], wide[W-1:0] == '0, ev, wide[W-1]);
      end
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule